// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control unit of a small processor that decides at each instruction boundary whether to enter an interrupt. The decision is made only when the core signals that an instruction has finished. If the global enable flag or the pending-interrupt flag is low, the core goes on to fetch the next instruction and nothing else happens. If both flags are high, the block runs a fixed series of steps, one per clock:

- move the stack pointer down by one;
- store the return address at the new top of stack;
- give the interrupt source a one-cycle acknowledge;
- load the program counter from the vector that the source presents;
- clear the global enable, so that further requests wait.

The block also carries out the matching return request. That request reads the saved address back into the program counter, moves the stack pointer up and re-enables interrupts. Program commands can set or clear the enable flag directly. While a sequence is running the block holds `busy` high, and the core stalls its fetch for that time. The core's program counter is held steady during entry, so the value on `pc_cur` is already the address of the next instruction.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the stack pointer is 0xFF (all ones), the enable flag is 0, and `busy`, `irq_ack`, `mem_we`, `mem_re` and `pc_ld` are all 0.
- R2: A pending interrupt is sampled only on a cycle where `instr_done` is high and `busy` is low. A pending flag with no such strobe starts nothing.
- R3: At an instruction end with the enable flag 0 or `irq_pend` 0, no entry starts. There is no memory write, no acknowledge and no PC load, and `busy` stays 0.
- R4: Entry starts when `instr_done`, the enable flag and `irq_pend` are all 1. The first step lowers the stack pointer by one, and the new value is visible two cycles after the strobe.
- R5: The cycle after the decrement, `mem_we` is high for one cycle, with `mem_addr` equal to the new stack pointer and `mem_wdata` equal to `pc_cur`.
- R6: `irq_ack` is high for exactly one cycle, in the cycle after the push.
- R7: The cycle after the acknowledge, `pc_ld` is high and `pc_ld_val` equals `vec_addr`.
- R8: The enable flag reads 0 from the cycle after the PC load. A request that stays pending then starts no new entry until the flag is set again.
- R9: `ien_set` sets the enable flag and `ien_clr` clears it, one cycle after the command. When both are high in the same cycle, clear wins.
- R10: When `instr_done` and `ret_req` are high together, the return has priority over an interrupt. First `mem_re` is high for one cycle with `mem_addr` equal to the stack pointer. In the next cycle `pc_ld` is high with `pc_ld_val` equal to `mem_rdata`, which the memory returns one cycle after the read. After that the stack pointer is one higher and the enable flag is 1.
- R11: The stack pointer wraps modulo 256. A return taken at 0xFF leaves 0x00, and an entry taken at 0x00 pushes to 0xFF.
- R12: `busy` is high from the cycle after the accepted strobe until the last step of the sequence ends. Any `instr_done` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | Strobe marking the end of an instruction |
| irq_pend | input | 1 | Interrupt status flag from the priority logic |
| vec_addr | input | 8 | Vector address from the interrupt hardware |
| ien_set | input | 1 | Program command to set the enable flag |
| ien_clr | input | 1 | Program command to clear the enable flag |
| ret_req | input | 1 | The finishing instruction is a return from interrupt |
| pc_cur | input | 8 | Address of the next instruction |
| mem_rdata | input | 8 | Stack read data, one cycle after `mem_re` |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 8 | Stack memory address |
| mem_wdata | output | 8 | Stack write data |
| pc_ld | output | 1 | Program counter load strobe |
| pc_ld_val | output | 8 | Value to load into the program counter |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| sp | output | 8 | Stack pointer |
| ien | output | 1 | Global interrupt enable flag |
| busy | output | 1 | Sequence running, fetch must stall |

## Verification
Some rules are checked on every cycle:

- a push writes exactly one below the previous stack pointer, and is followed by a single-cycle acknowledge;
- the acknowledge is followed by a vector load, and that load is followed by a cleared enable flag;
- the stack pointer only ever moves by one, with wraparound;
- an instruction end that does not qualify leaves the block idle.

Other behaviour can only be shown by the bench's scenarios:

- the exact values that are pushed and restored across a full entry-and-return round trip;
- the clear-wins rule for the enable commands;
- ignoring a strobe that arrives while busy;
- wrapping at both ends of the stack.

// File: rtl/irq_seq_pkg.sv
// Package: shared types for the interrupt entry sequencer.
// Assumes a one-hot-free binary state encoding is adequate for 7 states.
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DEC_SP  = 3'd1,
        ST_PUSH    = 3'd2,
        ST_ACK     = 3'd3,
        ST_LOAD_PC = 3'd4,
        ST_RET_RD  = 3'd5,
        ST_RET_LD  = 3'd6
    } seq_state_t;

    // Number of steps in the entry series (decrement, push, ack, load).
    localparam int unsigned ENTRY_STEPS = 4;

endpackage

// File: rtl/irq_seq_fsm.sv
// Module: irq_seq_fsm
// Steps through the entry series and the return series one per clock and
// decodes a strobe for each step. Assumes instr_done is only acted on in idle;
// a return request has priority over an interrupt at the same boundary.
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic ret_req,
    input  logic take_irq,
    output logic busy,
    output logic step_dec,
    output logic step_push,
    output logic step_ack,
    output logic step_vec,
    output logic step_rd,
    output logic step_rld
);

    seq_state_t state_q, state_d;

    // Next-state selection for the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_done && ret_req)       state_d = ST_RET_RD;
                else if (instr_done && take_irq) state_d = ST_DEC_SP;
                else                             state_d = ST_IDLE;
            end
            ST_DEC_SP:  state_d = ST_PUSH;
            ST_PUSH:    state_d = ST_ACK;
            ST_ACK:     state_d = ST_LOAD_PC;
            ST_LOAD_PC: state_d = ST_IDLE;
            ST_RET_RD:  state_d = ST_RET_LD;
            ST_RET_LD:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // One strobe per step, decoded from the current state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        step_dec  = (state_q == ST_DEC_SP);
        step_push = (state_q == ST_PUSH);
        step_ack  = (state_q == ST_ACK);
        step_vec  = (state_q == ST_LOAD_PC);
        step_rd   = (state_q == ST_RET_RD);
        step_rld  = (state_q == ST_RET_LD);
    end

endmodule

// File: rtl/irq_sp_reg.sv
// Module: irq_sp_reg
// Stack pointer register that steps down by one or up by one, wrapping
// modulo 2**ADDR_W. Assumes dec and inc are never high together.
module irq_sp_reg #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] sp
);

    localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

    // Update the pointer; arithmetic wraps naturally at the width.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_TOP;
        else if (dec) sp <= sp - ONE;
        else if (inc) sp <= sp + ONE;
    end

endmodule

// File: rtl/irq_ien_flag.sv
// Module: irq_ien_flag
// Global interrupt enable flag. Any clear source beats any set source.
// Assumes the sequencer clear and program commands may coincide.
module irq_ien_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_set,
    input  logic prog_clr,
    input  logic seq_set,
    input  logic seq_clr,
    output logic ien
);

    logic any_clr, any_set;

    // Combine the clear and set sources.
    always_comb begin
        any_clr = prog_clr | seq_clr;
        any_set = prog_set | seq_set;
    end

    // Flag register, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       ien <= 1'b0;
        else if (any_clr) ien <= 1'b0;
        else if (any_set) ien <= 1'b1;
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Samples the interrupt condition at each instruction end and runs the entry
// series (decrement SP, push PC, acknowledge, load vector, clear enable) or
// the return series (read top of stack, load PC, increment SP, set enable).
// Assumes the core holds pc_cur steady and stalls fetch while busy is high,
// and that the stack memory returns read data one cycle after mem_re.
module irq_entry_seq #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              irq_pend,
    input  logic [ADDR_W-1:0] vec_addr,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              pc_ld,
    output logic [ADDR_W-1:0] pc_ld_val,
    output logic              irq_ack,
    output logic [ADDR_W-1:0] sp,
    output logic              ien,
    output logic              busy
);

    logic take_irq;
    logic step_dec, step_push, step_ack, step_vec, step_rd, step_rld;

    // Entry is allowed only when both flags are set.
    always_comb take_irq = ien & irq_pend;

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .ret_req    (ret_req),
        .take_irq   (take_irq),
        .busy       (busy),
        .step_dec   (step_dec),
        .step_push  (step_push),
        .step_ack   (step_ack),
        .step_vec   (step_vec),
        .step_rd    (step_rd),
        .step_rld   (step_rld)
    );

    irq_sp_reg #(.ADDR_W(ADDR_W)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (step_dec),
        .inc   (step_rld),
        .sp    (sp)
    );

    irq_ien_flag u_ien (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_set (ien_set),
        .prog_clr (ien_clr),
        .seq_set  (step_rld),
        .seq_clr  (step_vec),
        .ien      (ien)
    );

    // Drive the memory port, PC load and acknowledge from the step strobes.
    always_comb begin
        mem_we    = step_push;
        mem_re    = step_rd;
        mem_addr  = sp;
        mem_wdata = pc_cur;
        irq_ack   = step_ack;
        pc_ld     = step_vec | step_rld;
        pc_ld_val = step_vec ? vec_addr : mem_rdata;
    end

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Module: irq_entry_seq_chk
// Cycle-level properties of the sequencer, bound to the top module.
module irq_entry_seq_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_done,
    input logic              irq_pend,
    input logic              ret_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pc_ld,
    input logic              irq_ack,
    input logic [ADDR_W-1:0] sp,
    input logic              ien,
    input logic              busy
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // R5: a push lands one below the pointer seen the cycle before.
    assert_push_below_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(rst_n)) |-> (mem_addr == $past(sp) - ONE));

    // R6: acknowledge follows the push and lasts a single cycle.
    assert_ack_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> irq_ack);
    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R7: the vector load follows the acknowledge.
    assert_load_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> pc_ld);

    // R8: enable is clear right after the entry load.
    assert_ien_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && $past(irq_ack)) |=> !ien);

    // R3: a non-qualifying instruction end leaves the block idle.
    assert_no_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && !busy && !ret_req && !(ien && irq_pend)) |=> !busy);

    // R11: the stack pointer only moves by one, modulo the width.
    assert_sp_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sp != $past(sp))) |->
            ((sp == $past(sp) - ONE) || (sp == $past(sp) + ONE)));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .irq_pend   (irq_pend),
    .ret_req    (ret_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pc_ld      (pc_ld),
    .irq_ack    (irq_ack),
    .sp         (sp),
    .ien        (ien),
    .busy       (busy)
);

// File: tb/test_irq_entry_seq.sv
// Scoreboard bench: driver tasks queue the expected bus events, a monitor
// pops and compares them at each falling edge.
module test_irq_entry_seq;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_done = 1'b0;
    logic          irq_pend = 1'b0;
    logic [AW-1:0] vec_addr = '0;
    logic          ien_set = 1'b0;
    logic          ien_clr = 1'b0;
    logic          ret_req = 1'b0;
    logic [AW-1:0] pc_cur = '0;
    logic [AW-1:0] mem_rdata;
    logic          mem_we, mem_re, pc_ld, irq_ack, ien, busy;
    logic [AW-1:0] mem_addr, mem_wdata, pc_ld_val, sp;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Event kinds: 1 write, 2 ack, 3 pc load, 4 read.
    typedef struct {
        int      kind;
        logic [AW-1:0] addr;
        logic [AW-1:0] data;
        string   req;
    } ev_t;
    ev_t exp_q[$];

    logic [AW-1:0] mem [0:255];

    always #2 clk = ~clk;

    irq_entry_seq #(.ADDR_W(AW)) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_pend(irq_pend),
        .vec_addr(vec_addr), .ien_set(ien_set), .ien_clr(ien_clr),
        .ret_req(ret_req), .pc_cur(pc_cur), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
        .irq_ack(irq_ack), .sp(sp), .ien(ien), .busy(busy)
    );

    // Stack memory model with a one-cycle read.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = AW'(i) ^ 8'hA5;
    end
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_ev(input int kind, input logic [AW-1:0] a,
                              input logic [AW-1:0] d);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(0, "R3", "unexpected bus event kind", kind, 0);
            return;
        end
        e = exp_q.pop_front();
        chk(e.kind == kind, e.req, "event kind", kind, e.kind);
        chk(e.addr == a, e.req, "event addr", a, e.addr);
        chk(e.data == d, e.req, "event data", d, e.data);
    endtask

    // Monitor: compare each observed event against the queue.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_we)  compare_ev(1, mem_addr, mem_wdata);
            if (irq_ack) compare_ev(2, '0, '0);
            if (pc_ld)   compare_ev(3, '0, pc_ld_val);
            if (mem_re)  compare_ev(4, mem_addr, '0);
        end
    end

    function automatic ev_t mk(input int k, input logic [AW-1:0] a,
                               input logic [AW-1:0] d, input string r);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.req = r;
        return e;
    endfunction

    // Pulse instr_done for one cycle; returns at the falling edge after it.
    task automatic pulse_done(input bit ret);
        @(negedge clk);
        instr_done = 1'b1; ret_req = ret;
        @(negedge clk);
        instr_done = 1'b0; ret_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_entry(input logic [AW-1:0] pc, input logic [AW-1:0] vec,
                            input logic [AW-1:0] sp_now);
        pc_cur = pc; vec_addr = vec;
        exp_q.push_back(mk(1, sp_now - 8'd1, pc, "R5"));
        exp_q.push_back(mk(2, '0, '0, "R6"));
        exp_q.push_back(mk(3, '0, vec, "R7"));
        pulse_done(1'b0);
        chk(busy == 1'b1, "R12", "busy after strobe", busy, 1);
        @(negedge clk);
        chk(sp == sp_now - 8'd1, "R4", "sp after decrement", sp, sp_now - 8'd1);
        wait_idle();
        chk(ien == 1'b0, "R8", "ien after entry", ien, 0);
    endtask

    task automatic do_return(input logic [AW-1:0] sp_now);
        exp_q.push_back(mk(4, sp_now, '0, "R10"));
        exp_q.push_back(mk(3, '0, mem[sp_now], "R10"));
        pulse_done(1'b1);
        wait_idle();
        chk(sp == sp_now + 8'd1, "R10", "sp after return", sp, sp_now + 8'd1);
        chk(ien == 1'b1, "R10", "ien after return", ien, 1);
    endtask

    task automatic prog_ien(input bit s, input bit c);
        @(negedge clk);
        ien_set = s; ien_clr = c;
        @(negedge clk);
        ien_set = 1'b0; ien_clr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            chk(0, "R12", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(sp == 8'hFF, "R1", "sp reset", sp, 8'hFF);
        chk(ien == 1'b0, "R1", "ien reset", ien, 0);
        chk(busy == 1'b0 && irq_ack == 1'b0 && pc_ld == 1'b0 &&
            mem_we == 1'b0 && mem_re == 1'b0, "R1", "outputs idle", busy, 0);

        // R3: pending but disabled.
        irq_pend = 1'b1;
        pulse_done(1'b0);
        chk(busy == 1'b0, "R3", "no entry with ien=0", busy, 0);

        // R9: set enable; R3: enabled but not pending.
        irq_pend = 1'b0;
        prog_ien(1'b1, 1'b0);
        chk(ien == 1'b1, "R9", "ien after set", ien, 1);
        pulse_done(1'b0);
        chk(busy == 1'b0, "R3", "no entry with pend=0", busy, 0);

        // R2: pending and enabled, but no instruction end.
        irq_pend = 1'b1;
        repeat (6) @(negedge clk);
        chk(busy == 1'b0 && sp == 8'hFF, "R2", "no entry without strobe", sp, 8'hFF);

        // R4..R8 and R12: full entry, extra strobe while busy ignored.
        pc_cur = 8'h42; vec_addr = 8'h10;
        exp_q.push_back(mk(1, 8'hFE, 8'h42, "R5"));
        exp_q.push_back(mk(2, '0, '0, "R6"));
        exp_q.push_back(mk(3, '0, 8'h10, "R7"));
        pulse_done(1'b0);
        chk(busy == 1'b1, "R12", "busy after strobe", busy, 1);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
        chk(sp == 8'hFE, "R4", "sp after decrement", sp, 8'hFE);
        wait_idle();
        chk(ien == 1'b0, "R8", "ien after entry", ien, 0);
        repeat (3) @(negedge clk);
        chk(sp == 8'hFE, "R12", "no second entry from busy strobe", sp, 8'hFE);

        // R8: still pending, ien clear, no entry.
        pulse_done(1'b0);
        chk(busy == 1'b0, "R8", "pending held off", busy, 0);

        // R10: return round trip restores 0x42.
        irq_pend = 1'b0;
        exp_q.push_back(mk(4, 8'hFE, '0, "R10"));
        exp_q.push_back(mk(3, '0, 8'h42, "R10"));
        pulse_done(1'b1);
        wait_idle();
        chk(sp == 8'hFF, "R10", "sp after return", sp, 8'hFF);
        chk(ien == 1'b1, "R10", "ien after return", ien, 1);

        // R9: simultaneous set and clear, clear wins.
        prog_ien(1'b1, 1'b1);
        chk(ien == 1'b0, "R9", "clear wins", ien, 0);
        prog_ien(1'b1, 1'b0);

        // R11: return at 0xFF wraps to 0x00, entry at 0x00 pushes to 0xFF.
        do_return(8'hFF);
        chk(sp == 8'h00, "R11", "sp wrapped up", sp, 8'h00);
        irq_pend = 1'b1;
        do_entry(8'h77, 8'h20, 8'h00);
        chk(sp == 8'hFF, "R11", "sp wrapped down", sp, 8'hFF);

        // R10: return priority over a pending interrupt with ien set.
        prog_ien(1'b1, 1'b0);
        do_return(8'hFF);
        chk(sp == 8'h00, "R10", "return took priority", sp, 8'h00);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule